// File: doc/BRIEF.md
# QPSK Frame Builder and Symbol Mapper

This block produces an endless stream of transmit frames and turns them into Gray-coded QPSK symbols. Each symbol is a pair of sign bits, one for the in-phase rail and one for the quadrature rail. Each frame holds 200 bits, which gives 100 symbols. The frame opens with a synchronisation header of 13 symbols. The header comes from a 13-element Barker sequence in which every element is sent twice, so that both bits of a header symbol are equal.

A 174-bit payload follows the header. Its first 105 bits spell out a fixed greeting followed by a three-digit decimal frame number. Each character is 7-bit ASCII, sent most significant bit first. A free-running 16-bit LFSR supplies the remaining payload bits as filler. Every payload bit, but no header bit, is XORed with the key stream of a 7-bit additive scrambler. The scrambler is reloaded at the start of each payload, which keeps ones and zeros balanced for a downstream timing-recovery loop.

Symbols leave through a valid/ready handshake, and a start-of-frame marker flags the first header symbol. The downstream pulse shaper pulls symbols whenever it needs them. Stalls of any length are allowed.

Top module: `qpsk_frame_mapper`

## Requirements
- R1: While `rst_n` is low, `sym_valid` is 0. From the first clock edge with `rst_n` high, `sym_valid` is 1 and stays 1. The first symbol offered is symbol 0 of frame 0, with `sym_sof` high.
- R2: A frame is exactly 100 transferred symbols. `sym_sof` is high on symbol 0 of every frame and low on the other 99.
- R3: Frame bits 0 to 25 form the header. Bits 2s and 2s+1 both equal element s of the Barker word 1111100110101, with element 0 at the left end (sent first). The header is never scrambled.
- R4: Payload bit p is frame bit 26+p. Payload bits 0 to 104 carry the 15 characters "Hello world " followed by three decimal digits. Each character is 7-bit ASCII, most significant bit first, character 0 first.
- R5: The three digits are the frame number. Frame 0 carries "000". The number rises by one per frame and returns to 000 after 099.
- R6: Payload bits 105 to 173 come from a 16-bit filler LFSR seeded with 16'hACE1 at reset. Each filler bit is the XOR of state bits 15, 13, 12 and 10, and it is then shifted into bit 0. The LFSR advances only on filler bits and keeps its state across frames.
- R7: Each payload bit is sent XORed with a key bit from a 7-bit scrambler. The scrambler is loaded with 7'h7F before the first payload bit of every frame. Each key bit is the XOR of state bits 6 and 3, and it is shifted into bit 0.
- R8: For symbol s, frame bit 2s drives `sym_i_neg` and bit 2s+1 drives `sym_q_neg`, where 1 means a negative rail. The four quadrants in circular order carry the codes 00, 10, 11, 01, so neighbours differ in one bit.
- R9: A symbol transfers on a clock edge where `sym_valid` and `sym_ready` are both high. While `sym_ready` is low, all outputs hold and the stream position does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_ready | input | 1 | Consumer accepts the current symbol |
| sym_valid | output | 1 | A symbol is offered |
| sym_sof | output | 1 | Offered symbol is the first of a frame |
| sym_i_neg | output | 1 | In-phase sign bit, 1 = negative |
| sym_q_neg | output | 1 | Quadrature sign bit, 1 = negative |

## Verification
A wrong symbol index shows up at once as a misplaced `sym_sof` or as a broken Barker pattern in the header. A scrambler that is out of step corrupts every payload symbol that follows, from the first symbol after the header. A filler LFSR in the wrong state shows no error until symbol 65 of a frame, where the filler region begins, and then shows it in every later frame. A wrong frame counter changes only three characters per frame, so the bench descrambles the captured payloads and compares the decoded text, including the frame after 099.

// File: rtl/qfm_pkg.sv
// Package: frame geometry and fixed text shared by the frame mapper modules.
// Assumes a 200-bit frame with two bits per QPSK symbol.
package qfm_pkg;
    localparam int FRAME_SYMS   = 100;
    localparam int SYM_BITS     = 2;
    localparam int FRAME_BITS   = FRAME_SYMS * SYM_BITS;
    localparam int HDR_SYMS     = 13;
    localparam int HDR_BITS     = HDR_SYMS * SYM_BITS;
    localparam int CHAR_BITS    = 7;
    localparam int GREET_CHARS  = 12;
    localparam int DIGIT_CHARS  = 3;
    localparam int MSG_BITS     = (GREET_CHARS + DIGIT_CHARS) * CHAR_BITS;
    localparam int SYM_IDX_W    = $clog2(FRAME_SYMS);
    localparam int BIT_POS_W    = $clog2(FRAME_BITS);
    localparam logic [8*GREET_CHARS-1:0] GREETING = "Hello world ";
endpackage

// File: rtl/qfm_frame_counter.sv
// Module: tracks the symbol position inside a frame and the two-digit BCD
// frame number (the hundreds digit is always zero).
// Assumes advance is high only on a completed symbol transfer.
module qfm_frame_counter
    import qfm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    output logic [SYM_IDX_W-1:0] sym_idx,
    output logic [3:0]           tens,
    output logic [3:0]           ones,
    output logic                 frame_last
);
    assign frame_last = (sym_idx == SYM_IDX_W'(FRAME_SYMS - 1));

    // Step the symbol index, and the frame number at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_idx <= '0;
            tens    <= '0;
            ones    <= '0;
        end else if (advance) begin
            if (frame_last) begin
                sym_idx <= '0;
                if (ones == 4'd9) begin
                    ones <= '0;
                    tens <= (tens == 4'd9) ? 4'd0 : tens + 4'd1;
                end else begin
                    ones <= ones + 4'd1;
                end
            end else begin
                sym_idx <= sym_idx + SYM_IDX_W'(1);
            end
        end
    end

    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance && frame_last |=> sym_idx == '0);
    // R5
    digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tens <= 4'd9 && ones <= 4'd9);
endmodule

// File: rtl/qfm_lfsr.sv
// Module: Fibonacci LFSR that can advance zero, one or two steps per cycle.
// Each output bit is the XOR of the tapped state bits, which is then
// shifted into bit 0. out0 comes before out1 in the bit stream.
// Assumes a nonzero SEED and a reload that takes priority over stepping.
module qfm_lfsr #(
    parameter int            WIDTH = 7,
    parameter logic [WIDTH-1:0] TAPS = 7'h48,
    parameter logic [WIDTH-1:0] SEED = 7'h7F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reload,
    input  logic [1:0] steps,
    output logic       out0,
    output logic       out1
);
    logic [WIDTH-1:0] state, state1, state2;

    // Look two steps ahead of the current state.
    always_comb begin
        out0   = ^(state & TAPS);
        state1 = {state[WIDTH-2:0], out0};
        out1   = ^(state1 & TAPS);
        state2 = {state1[WIDTH-2:0], out1};
    end

    // Load the seed or take the requested number of steps.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) state <= SEED;
        else if (steps == 2'd1) state <= state1;
        else if (steps == 2'd2) state <= state2;
    end

    // R6 R7
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);
endmodule

// File: rtl/qfm_text_bits.sv
// Module: returns one bit of the 15-character message for a payload position.
// Characters are 7-bit ASCII sent MSB first. The last three characters are
// '0' and the two BCD frame digits. Positions past the message return 0.
module qfm_text_bits
    import qfm_pkg::*;
(
    input  logic [BIT_POS_W-1:0] pay_pos,
    input  logic [3:0]           tens,
    input  logic [3:0]           ones,
    output logic                 txt_bit
);
    int         ci;
    int         bi;
    logic [7:0] ch;
    logic [2:0] bsel;

    // Find the character and the bit within it, then pick the bit.
    always_comb begin
        ci = int'(pay_pos) / CHAR_BITS;
        bi = int'(pay_pos) % CHAR_BITS;
        if (ci < GREET_CHARS)                 ch = GREETING[8*(GREET_CHARS-1-ci) +: 8];
        else if (ci == GREET_CHARS)           ch = 8'h30;
        else if (ci == GREET_CHARS + 1)       ch = {4'h3, tens};
        else if (ci == GREET_CHARS + 2)       ch = {4'h3, ones};
        else                                  ch = 8'h00;
        bsel    = 3'(CHAR_BITS - 1 - bi);
        txt_bit = ch[bsel];
    end
endmodule

// File: rtl/qpsk_frame_mapper.sv
// Module: top of the QPSK frame builder. It assembles the Barker header, the
// text payload with the frame number and the LFSR filler, scrambles the
// payload and offers one Gray-coded sign pair per cycle over valid/ready.
// Assumes the consumer may stall for any number of cycles.
module qpsk_frame_mapper
    import qfm_pkg::*;
#(
    parameter logic [HDR_SYMS-1:0] BARKER   = 13'b1111100110101,
    parameter logic [6:0]          SCR_SEED = 7'h7F,
    parameter logic [15:0]         FIL_SEED = 16'hACE1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sym_ready,
    output logic sym_valid,
    output logic sym_sof,
    output logic sym_i_neg,
    output logic sym_q_neg
);
    logic                 fire, frame_last, in_hdr_sym, hdr_bit;
    logic [SYM_IDX_W-1:0] sym_idx;
    logic [3:0]           tens, ones;
    logic [1:0]           is_fill, is_msg, txt_bits, key, fil, data, lane_bit;
    logic [1:0]           scr_steps, fil_steps;
    logic [3:0]           hdr_sel;

    assign fire = sym_valid && sym_ready;

    // Offer symbols from the first edge after reset onwards.
    always_ff @(posedge clk) begin
        if (!rst_n) sym_valid <= 1'b0;
        else        sym_valid <= 1'b1;
    end

    qfm_frame_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .advance(fire), .sym_idx(sym_idx),
        .tens(tens), .ones(ones), .frame_last(frame_last)
    );

    // Header lookup: element 0 of the Barker word sits at its MSB.
    assign in_hdr_sym = (sym_idx < SYM_IDX_W'(HDR_SYMS));
    assign hdr_sel    = in_hdr_sym ? 4'(HDR_SYMS - 1) - 4'(sym_idx) : 4'd0;
    assign hdr_bit    = BARKER[hdr_sel];

    for (genvar j = 0; j < SYM_BITS; j++) begin : g_lane
        logic [BIT_POS_W-1:0] fpos, ppos;
        assign fpos       = {sym_idx, 1'b0} | BIT_POS_W'(j);
        assign ppos       = fpos - BIT_POS_W'(HDR_BITS);
        assign is_msg[j]  = !in_hdr_sym && (ppos < BIT_POS_W'(MSG_BITS));
        assign is_fill[j] = !in_hdr_sym && !is_msg[j];
        qfm_text_bits u_txt (
            .pay_pos(ppos), .tens(tens), .ones(ones), .txt_bit(txt_bits[j])
        );
    end

    // Lane 1 takes the first filler bit when lane 0 still carries text.
    assign data[0] = is_msg[0] ? txt_bits[0] : fil[0];
    assign data[1] = is_msg[1] ? txt_bits[1] : (is_fill[0] ? fil[1] : fil[0]);
    assign fil_steps = fire ? {1'b0, is_fill[0]} + {1'b0, is_fill[1]} : 2'd0;
    assign scr_steps = (fire && !in_hdr_sym) ? 2'd2 : 2'd0;

    qfm_lfsr #(.WIDTH(16), .TAPS(16'hB400), .SEED(FIL_SEED)) u_fill (
        .clk(clk), .rst_n(rst_n), .reload(1'b0), .steps(fil_steps),
        .out0(fil[0]), .out1(fil[1])
    );

    qfm_lfsr #(.WIDTH(7), .TAPS(7'h48), .SEED(SCR_SEED)) u_scr (
        .clk(clk), .rst_n(rst_n), .reload(fire && frame_last), .steps(scr_steps),
        .out0(key[0]), .out1(key[1])
    );

    // Scramble payload bits, pass header bits, map to sign pairs.
    assign lane_bit  = in_hdr_sym ? {hdr_bit, hdr_bit} : (data ^ key);
    assign sym_i_neg = lane_bit[0];
    assign sym_q_neg = lane_bit[1];
    assign sym_sof   = sym_valid && (sym_idx == '0);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && !sym_ready |=> sym_valid && $stable({sym_sof, sym_i_neg, sym_q_neg}));
    // R1
    valid_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sym_valid) |-> sym_sof);
    // R3
    header_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid && in_hdr_sym |-> sym_i_neg == sym_q_neg);
    // R1
    valid_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |=> sym_valid);
endmodule

// File: tb/qpsk_frame_mapper_test.sv
module qpsk_frame_mapper_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_ready = 1'b0;
    logic sym_valid, sym_sof, sym_i_neg, sym_q_neg;

    int checks = 0;
    int errors = 0;

    // Bench reference state
    logic        exp_bits [200];
    logic        cap_bits [200];
    int          model_fn = 0;
    int          cap_fn = 0;
    logic [15:0] fst = 16'hACE1;
    int          pos = 0;
    bit          held_valid = 0;
    logic [2:0]  held;

    always #(CLK_PERIOD/2) clk = ~clk;

    qpsk_frame_mapper uut (
        .clk(clk), .rst_n(rst_n), .sym_ready(sym_ready), .sym_valid(sym_valid),
        .sym_sof(sym_sof), .sym_i_neg(sym_i_neg), .sym_q_neg(sym_q_neg)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Build the expected 200 frame bits for frame number fn (R3 R4 R6 R7).
    task automatic gen_frame(input int fn);
        logic [12:0] bk = 13'b1111100110101;
        string       msg = $sformatf("Hello world %03d", fn);
        logic        d [174];
        logic [6:0]  sst = 7'h7F;
        for (int i = 0; i < 13; i++) begin
            exp_bits[2*i]   = bk[12-i];
            exp_bits[2*i+1] = bk[12-i];
        end
        for (int p = 0; p < 174; p++) begin
            if (p < 105) begin
                logic [7:0] c = msg[p/7];
                d[p] = c[6 - p%7];
            end else begin
                logic o = fst[15] ^ fst[13] ^ fst[12] ^ fst[10];
                fst  = {fst[14:0], o};
                d[p] = o;
            end
        end
        for (int p = 0; p < 174; p++) begin
            logic k = sst[6] ^ sst[3];
            sst = {sst[5:0], k};
            exp_bits[26+p] = d[p] ^ k;
        end
    endtask

    // Run until n symbols transfer; mode 1 inserts stalls.
    task automatic run_syms(input int n, input int mode);
        int done = 0;
        int cyc = 0;
        while (done < n) begin
            bit rdy = (mode == 0) || (cyc % 3 != 1 && cyc % 7 != 5);
            @(negedge clk);
            sym_ready = rdy;
            cyc++;
            if (held_valid)
                chk({sym_sof, sym_i_neg, sym_q_neg} == held && sym_valid, "R9", "outputs held in stall",
                    int'({sym_sof, sym_i_neg, sym_q_neg}), int'(held));
            held_valid = sym_valid && !rdy;
            held = {sym_sof, sym_i_neg, sym_q_neg};
            if (sym_valid && rdy) begin
                string tag = (pos < 13) ? "R3" : (pos < 66) ? "R4 R8" : "R6 R7";
                chk(sym_sof == (pos == 0), "R2", $sformatf("sof at symbol %0d", pos),
                    int'(sym_sof), int'(pos == 0));
                chk({sym_i_neg, sym_q_neg} == {exp_bits[2*pos], exp_bits[2*pos+1]}, tag,
                    $sformatf("sign pair frame %0d symbol %0d", model_fn, pos),
                    int'({sym_i_neg, sym_q_neg}), int'({exp_bits[2*pos], exp_bits[2*pos+1]}));
                cap_bits[2*pos]   = sym_i_neg;
                cap_bits[2*pos+1] = sym_q_neg;
                pos++;
                done++;
                if (pos == 100) begin
                    pos = 0;
                    cap_fn = model_fn;
                    model_fn = (model_fn + 1) % 100;
                    gen_frame(model_fn);
                end
            end
        end
        @(negedge clk);
        sym_ready = 1'b0;
        held_valid = 0;
    endtask

    // Descramble the last captured frame and compare its text (R4 R5 R7).
    task automatic check_text(input int want_fn);
        logic [6:0] sst = 7'h7F;
        string      want = $sformatf("Hello world %03d", want_fn);
        int         bad = 0;
        logic [7:0] first_bad = 0;
        for (int c = 0; c < 15; c++) begin
            logic [7:0] ch = 0;
            for (int b = 0; b < 7; b++) begin
                logic k = sst[6] ^ sst[3];
                sst = {sst[5:0], k};
                ch[6-b] = cap_bits[26 + 7*c + b] ^ k;
            end
            if (ch != want[c]) begin
                if (bad == 0) first_bad = ch;
                bad++;
            end
        end
        chk(bad == 0, "R5", $sformatf("decoded text of frame %0d (mismatching chars)", want_fn), bad, 0);
        chk(cap_fn == want_fn, "R4", "captured frame number", cap_fn, want_fn);
        if (bad != 0) $display("  first wrong char 0x%0h", first_bad);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk(sym_valid == 1'b0, "R1", "valid in reset", int'(sym_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sym_valid == 1'b1, "R1", "valid after reset", int'(sym_valid), 1);
        chk(sym_sof == 1'b1, "R1", "sof on first symbol", int'(sym_sof), 1);
        repeat (3) @(negedge clk);
        chk(sym_valid && sym_sof, "R9", "no advance with ready low", int'({sym_valid, sym_sof}), 3);
    endtask

    task automatic test_first_frame();
        run_syms(100, 0);
        check_text(0);
    endtask

    task automatic test_stalls();
        run_syms(200, 1);
        check_text(2);
    endtask

    task automatic test_counter_wrap();
        run_syms(97 * 100, 0);
        check_text(99);
        run_syms(100, 1);
        check_text(0);
        run_syms(150, 0);
        chk(pos == 50, "R2", "bench position mid frame", pos, 50);
    endtask

    initial begin
        gen_frame(0);
        test_reset();
        test_first_frame();
        test_stalls();
        test_counter_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule